// File: doc/BRIEF.md
# Two-Wire Digital Potentiometer Wiper Controller

This block is the digital half of a single-channel digitally controlled potentiometer. It holds a 7-bit volatile wiper code that a host reaches as a slave on a two-wire serial bus. It also decodes that code into a one-hot tap-select bus, one line for each switch of a 128-position resistor ladder. The host writes the code with a three-byte transfer: the slave address with the direction bit clear, a pointer byte, and the data byte. It reads the code back with a transfer that has the direction bit set. Every byte goes most significant bit first.

The serial clock and data inputs pass through a two-stage synchronizer and are sampled on the system clock. The block only pulls the data line low and never drives it high. The bus master generates every clock edge.

Top module: `dpot_wiper_top`

## Requirements
- R1: After reset the wiper code is 64, tap-select line 64 alone is high, and the data line is released (pull-low output 0).
- R2: The tap-select bus always has exactly one line high. Its index equals the wiper code, so code 0 selects line 0 (low end) and code 127 selects line 127 (high end).
- R3: A write transfer is acknowledged on all three bytes: the address byte with the direction bit (bit 0) equal to 0, a pointer byte of any value, and a data byte. The wiper then takes data bits 6..0. Data bit 7 is ignored.
- R4: A read transfer (address byte with bit 0 equal to 1) is acknowledged. The block then returns the wiper code as a byte with bit 7 equal to 0, MSB first. It sends the byte again after each master ACK and releases the data line after a master NACK.
- R5: An address byte whose bits 7..1 differ from the slave address parameter gets no acknowledge, and the block never pulls the line during that transfer. The wiper is left unchanged.
- R6: A STOP or a repeated START during a transfer ends that transfer without changing the wiper. A repeated START begins a new address phase.
- R7: The pull-low output changes only while the serial clock is low.
- R8: Further bytes after the data byte of a write are not acknowledged and do not change the wiper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaPullLow | output | 1 | When 1, the open-drain pad pulls the data line low |
| tapSel | output | 128 | One-hot ladder switch select |

## Verification
Directed writes of the end codes 0 and 127 show that the decoder maps both ends correctly. A data byte with bit 7 set shows whether that bit is masked off. Random codes sent to random pointer values exercise the full write and read-back path. A share of these transfers goes to foreign addresses, which separates address matching from data handling. Transfers cut short by a STOP or a repeated START, trailing extra bytes, and a two-byte read show that the control sequence aborts, refuses bytes and repeats where the requirements say it must.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  // Strobes from bus control to the wiper datapath
  typedef struct packed {
    logic rxShift;  // shift sampled data bit into receive register
    logic rxBit;    // the sampled data bit
    logic txLoad;   // load transmit register from the wiper
    logic txShift;  // advance transmit register by one bit
    logic wiperWr;  // commit received byte to the wiper
  } dpStrobe_t;

  typedef enum logic [3:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_ADDR_ACK,
    BUS_PTR,
    BUS_PTR_ACK,
    BUS_DATA,
    BUS_DATA_ACK,
    BUS_RD_BYTE,
    BUS_RD_ACK,
    BUS_RD_AGAIN,
    BUS_IGNORE
  } busState_t;

endpackage

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl
  import dpot_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h2E,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned TX_W = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txNextBit,
  output dpStrobe_t         strb,
  output logic              sdaDrive
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [2:0] sclSync, sdaSync;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic byteFull;
  logic rwBit;
  logic rxPhase;

  assign sclNow = sclSync[1];
  assign sclOld = sclSync[2];
  assign sdaNow = sdaSync[1];
  assign sdaOld = sdaSync[2];

  assign sclRise  = sclNow && !sclOld;
  assign sclFall  = !sclNow && sclOld;
  assign startDet = sclNow && sclOld && sdaOld && !sdaNow;
  assign stopDet  = sclNow && sclOld && !sdaOld && sdaNow;

  assign rxPhase = (state == BUS_ADDR) || (state == BUS_PTR) || (state == BUS_DATA);

  always_comb begin
    strb.rxShift = sclRise && rxPhase;
    strb.rxBit   = sdaNow;
    strb.txLoad  = sclFall && (((state == BUS_ADDR_ACK) && rwBit) || (state == BUS_RD_AGAIN));
    strb.txShift = sclFall && (state == BUS_RD_BYTE) && (bitCnt != LAST_BIT);
    strb.wiperWr = sclFall && (state == BUS_DATA_ACK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync  <= '1;
      sdaSync  <= '1;
      state    <= BUS_IDLE;
      bitCnt   <= '0;
      byteFull <= 1'b0;
      rwBit    <= 1'b0;
      sdaDrive <= 1'b0;
    end else begin
      sclSync <= {sclSync[1:0], sclIn};
      sdaSync <= {sdaSync[1:0], sdaIn};
      if (stopDet) begin
        state    <= BUS_IDLE;
        byteFull <= 1'b0;
        sdaDrive <= 1'b0;
      end else if (startDet) begin
        state    <= BUS_ADDR;
        bitCnt   <= '0;
        byteFull <= 1'b0;
        sdaDrive <= 1'b0;
      end else begin
        unique case (state)
          BUS_ADDR, BUS_PTR, BUS_DATA: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) byteFull <= 1'b1;
            end else if (sclFall && byteFull) begin
              byteFull <= 1'b0;
              bitCnt   <= '0;
              if (state == BUS_ADDR) begin
                if (rxByte[BYTE_W-1:1] == SLAVE_ADDR) begin
                  sdaDrive <= 1'b1;
                  rwBit    <= rxByte[0];
                  state    <= BUS_ADDR_ACK;
                end else begin
                  state <= BUS_IGNORE;
                end
              end else if (state == BUS_PTR) begin
                sdaDrive <= 1'b1;
                state    <= BUS_PTR_ACK;
              end else begin
                sdaDrive <= 1'b1;
                state    <= BUS_DATA_ACK;
              end
            end
          end
          BUS_ADDR_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rwBit) begin
                sdaDrive <= 1'b1;  // leading bit of the reply is always 0
                state    <= BUS_RD_BYTE;
              end else begin
                sdaDrive <= 1'b0;
                state    <= BUS_PTR;
              end
            end
          end
          BUS_PTR_ACK: begin
            if (sclFall) begin
              sdaDrive <= 1'b0;
              state    <= BUS_DATA;
            end
          end
          BUS_DATA_ACK: begin
            if (sclFall) begin
              sdaDrive <= 1'b0;
              state    <= BUS_IGNORE;
            end
          end
          BUS_RD_BYTE: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaDrive <= 1'b0;
                state    <= BUS_RD_ACK;
              end else begin
                sdaDrive <= !txNextBit;
                bitCnt   <= bitCnt + 1'b1;
              end
            end
          end
          BUS_RD_ACK: begin
            if (sclRise) state <= sdaNow ? BUS_IGNORE : BUS_RD_AGAIN;
          end
          BUS_RD_AGAIN: begin
            if (sclFall) begin
              sdaDrive <= 1'b1;
              bitCnt   <= '0;
              state    <= BUS_RD_BYTE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: the pull-low only moves on a falling clock, never while SCL is held high
  a_r7_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclNow && sclOld && !startDet && !stopDet) |=> $stable(sdaDrive));

  // R6: a STOP always leaves the line released
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDrive);

  // R5: a foreign address is never acknowledged
  a_r5_foreign_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    ((state == BUS_ADDR) && sclFall && byteFull && !startDet && !stopDet &&
     (rxByte[BYTE_W-1:1] != SLAVE_ADDR)) |=> !sdaDrive);

endmodule

// File: rtl/dpot_wiper_dp.sv
module dpot_wiper_dp
  import dpot_pkg::*;
#(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned RESET_CODE = 64,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned TX_W = BYTE_W - 1,
  parameter int unsigned TAPS = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txNextBit,
  output logic [TAPS-1:0]   tapSel
);

  logic [CODE_W-1:0] wiper;
  logic [TX_W-1:0]   txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txReg  <= '0;
      wiper  <= CODE_W'(RESET_CODE);
    end else begin
      if (strb.rxShift) rxByte <= {rxByte[BYTE_W-2:0], strb.rxBit};
      if (strb.txLoad) txReg <= TX_W'(wiper);
      else if (strb.txShift) txReg <= txReg << 1;
      if (strb.wiperWr) wiper <= rxByte[CODE_W-1:0];
    end
  end

  assign txNextBit = txReg[TX_W-1];

  // Ladder decoder: one comparator per tap
  generate
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tapSel[t] = (wiper == CODE_W'(t));
    end
  endgenerate

  // R2: exactly one ladder switch closed
  a_r2_one_tap: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel) == 1);

  // R3: a commit takes the low bits of the received byte
  a_r3_commit_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.wiperWr |=> wiper == $past(rxByte[CODE_W-1:0]));

  // R6/R8: without a commit strobe the wiper holds
  a_r6_wiper_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wiperWr |=> $stable(wiper));

endmodule

// File: rtl/dpot_wiper_top.sv
module dpot_wiper_top
  import dpot_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2E,
  parameter int unsigned CODE_W = 7,
  parameter int unsigned RESET_CODE = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  output logic                     sdaPullLow,
  output logic [(1 << CODE_W)-1:0] tapSel
);

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TX_W = BYTE_W - 1;

  dpStrobe_t strb;
  logic [BYTE_W-1:0] rxByte;
  logic txNextBit;

  dpot_i2c_ctrl #(
    .ADDR_W(7), .SLAVE_ADDR(SLAVE_ADDR), .BYTE_W(BYTE_W), .TX_W(TX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txNextBit(txNextBit), .strb(strb), .sdaDrive(sdaPullLow)
  );

  dpot_wiper_dp #(
    .CODE_W(CODE_W), .RESET_CODE(RESET_CODE), .BYTE_W(BYTE_W), .TX_W(TX_W),
    .TAPS(1 << CODE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxByte(rxByte), .txNextBit(txNextBit), .tapSel(tapSel)
  );

endmodule

// File: tb/dpot_wiper_top_tb_top.sv
`timescale 1ns/1ps
module dpot_wiper_top_tb_top;

  localparam logic [6:0] MY_ADDR = 7'h2E;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic [127:0] tapSel;
  logic sdaBus;

  int nChecks = 0;
  int nFail = 0;
  int r7Viol = 0;
  logic [6:0] expWiper;

  assign sdaBus = sdaM & ~sdaPullLow;

  always #2.5 clk = ~clk;

  dpot_wiper_top #(.SLAVE_ADDR(MY_ADDR)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .sdaPullLow(sdaPullLow), .tapSel(tapSel)
  );

  function automatic logic [127:0] tapFor(input logic [6:0] code);
    return 128'b1 << code;
  endfunction

  function automatic logic [7:0] replyFor(input logic [6:0] code);
    return {1'b0, code};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  // R7 monitor: the pull-low must not move while SCL stays high
  logic prevScl = 1'b1, prevPull = 1'b0;
  always @(negedge clk) begin
    if (rstN && scl && prevScl && (sdaPullLow !== prevPull)) r7Viol++;
    prevScl  <= scl;
    prevPull <= sdaPullLow;
  end

  task automatic busStart;
    sdaM = 1'b1; waitClk(Q); scl = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q); scl = 1'b0; waitClk(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitClk(Q); scl = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(2 * Q);
  endtask

  task automatic txBit(input logic b);
    sdaM = b; waitClk(Q); scl = 1'b1; waitClk(2 * Q); scl = 1'b0; waitClk(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) txBit(b[i]);
    sdaM = 1'b1; waitClk(Q); scl = 1'b1; waitClk(Q);
    acked = ~sdaBus;
    waitClk(Q); scl = 1'b0; waitClk(Q);
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitClk(Q); scl = 1'b1; waitClk(Q);
      b[i] = sdaBus;
      waitClk(Q); scl = 1'b0; waitClk(Q);
    end
    txBit(~masterAck);
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] ptr, input logic [7:0] data,
                         input string req);
    logic k0, k1, k2;
    logic match;
    match = (a == MY_ADDR);
    busStart;
    sendByte({a, 1'b0}, k0);
    if (match) begin
      sendByte(ptr, k1);
      sendByte(data, k2);
    end else begin
      k1 = 1'b0; k2 = 1'b0;
    end
    busStop;
    if (match) expWiper = data[6:0];
    chk({req, " address ack"}, 128'(k0), 128'(match));
    if (match) begin
      chk({req, " pointer ack"}, 128'(k1), 128'(1));
      chk({req, " data ack"}, 128'(k2), 128'(1));
    end
    waitClk(2);
    chk({req, " R2 tap"}, tapSel, tapFor(expWiper));
  endtask

  task automatic doRead(input int nBytes, input string req);
    logic k0;
    logic [7:0] b;
    busStart;
    sendByte({MY_ADDR, 1'b1}, k0);
    chk({req, " R4 read address ack"}, 128'(k0), 128'(1));
    for (int n = 0; n < nBytes; n++) begin
      readByte(n != nBytes - 1, b);
      chk({req, " R4 read byte"}, 128'(b), 128'(replyFor(expWiper)));
    end
    waitClk(Q);
    chk({req, " R4 released after NACK"}, 128'(sdaPullLow), 128'(0));
    busStop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report;
    $finish;
  end

  initial begin
    logic k;
    expWiper = 7'd64;
    void'($urandom(32'd4711));
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1: reset state
    chk("R1 reset tap", tapSel, tapFor(7'd64));
    chk("R1 reset release", 128'(sdaPullLow), 128'(0));
    doRead(1, "R1 reset readback");

    // R2/R3: end codes, bit 7 masked
    doWrite(MY_ADDR, 8'h00, 8'h00, "R3 low end");
    doRead(1, "R2 low end");
    doWrite(MY_ADDR, 8'h5A, 8'hFF, "R3 bit7 ignored high end");
    chk("R3 bit7 ignored", tapSel, tapFor(7'h7F));
    doRead(2, "R4 repeated read");

    // R5: foreign address
    doWrite(7'h2F, 8'h00, 8'h11, "R5 foreign");
    chk("R5 wiper unchanged", tapSel, tapFor(7'h7F));

    // R6: STOP inside the data byte
    doWrite(MY_ADDR, 8'h01, 8'h33, "R6 setup");
    busStart;
    sendByte({MY_ADDR, 1'b0}, k);
    sendByte(8'h00, k);
    for (int i = 0; i < 4; i++) txBit(1'b0);
    busStop;
    waitClk(4);
    chk("R6 stop abort", tapSel, tapFor(7'h33));

    // R6: repeated START after pointer, then read in the new phase
    busStart;
    sendByte({MY_ADDR, 1'b0}, k);
    sendByte(8'h00, k);
    busStart;
    sendByte({MY_ADDR, 1'b1}, k);
    chk("R6 restart address ack", 128'(k), 128'(1));
    begin
      logic [7:0] b;
      readByte(1'b0, b);
      chk("R6 restart read", 128'(b), 128'(replyFor(7'h33)));
    end
    busStop;
    chk("R6 restart keeps wiper", tapSel, tapFor(7'h33));

    // R8: trailing byte after data
    busStart;
    sendByte({MY_ADDR, 1'b0}, k);
    sendByte(8'h00, k);
    sendByte(8'h15, k);
    sendByte(8'h66, k);
    chk("R8 extra byte nack", 128'(k), 128'(0));
    busStop;
    waitClk(2);
    chk("R8 extra byte ignored", tapSel, tapFor(7'h15));
    expWiper = 7'h15;

    // Random mix
    for (int it = 0; it < 40; it++) begin
      logic [6:0] a;
      logic [7:0] d, p;
      a = (($urandom % 5) == 0) ? 7'($urandom) : MY_ADDR;
      d = 8'($urandom);
      p = 8'($urandom);
      doWrite(a, p, d, "R3 random");
      doRead(1 + ($urandom % 2), "R4 random");
    end

    chk("R7 pull-low moved with SCL high", 128'(r7Viol), 128'(0));
    report;
    $finish;
  end

endmodule